// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block holds received characters for a 16550-style UART between the deserializer and the processor read port. Each of its 16 slots keeps a data byte together with that byte's parity, framing and break flags. The flags stay in the queue with their byte. They reach the line-status bits only when that byte becomes the oldest one in the queue, so software sees each error next to the character that caused it.

The block also produces the receive-side status and events. It drives data-ready, overrun, the three per-character error bits and an error summary. It raises a data event when the fill reaches a trigger level picked by a 2-bit selector. It raises a timeout event when the queue holds data but has been neither written nor read for four character times. The clocks per character come in as an input, computed elsewhere from the divisor and the frame settings. Interrupt prioritization and serial reception are handled outside this block.

Top module: `uart_rx_queue`

## Requirements
- R1: Bytes leave the queue in the order they were accepted, and `rd_data` shows the oldest byte whenever `data_ready` is 1.
- R2: `rx_level` equals the number of stored bytes, changes by at most one per cycle, and `data_ready` is 1 exactly when `rx_level` is nonzero.
- R3: A push while 16 bytes are stored and no pop is taking place discards the byte. The stored contents and level stay unchanged, and `overrun` and `err_summary` are 1 from the next cycle.
- R4: A byte pushed into an empty queue merges its flags into `parity_err`, `framing_err` and `break_det` on the next cycle, and sets `err_summary` if any of them is 1.
- R5: The flags of a byte behind the oldest one stay out of the status bits. They are merged on the cycle after the pop that makes this byte the oldest.
- R6: A `lsr_read` pulse clears `overrun`, `parity_err`, `framing_err`, `break_det` and `err_summary`. A new error flag merged in the same cycle wins over the clear.
- R7: `data_event` is 1 while `rx_level` is at least the trigger level. For `trig_sel` values 0, 1, 2 and 3 the levels are 1, 4, 8 and 14.
- R8: Every push, and every pop that leaves data behind, restarts the timeout. `timeout_event` goes to 1 exactly 4 × `char_clks` cycles after the restart edge, and stays at 1 until the next push, pop or clear.
- R9: A pop that empties the queue stops the timeout, and `timeout_event` then stays at 0.
- R10: `fifo_clear` empties the queue and drops `data_ready`, `data_event` and `timeout_event` on the next cycle, while leaving the error bits unchanged. A push in the same cycle is ignored.
- R11: A pop while the queue is empty has no effect on the level or the status.
- R12: `line_event` is 1 while any of `overrun`, `parity_err`, `framing_err` or `break_det` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | One received character is offered this cycle |
| push_data | input | 8 | Received byte |
| push_par | input | 1 | Parity error flag of the byte |
| push_frm | input | 1 | Framing error flag of the byte |
| push_brk | input | 1 | Break flag of the byte |
| pop | input | 1 | Read strobe of the receive data register |
| trig_sel | input | 2 | Trigger level select (0..3 → 1, 4, 8, 14) |
| fifo_clear | input | 1 | Empties the queue |
| lsr_read | input | 1 | Line-status read, clears the error bits |
| char_clks | input | 12 | Clock cycles per character |
| rd_data | output | 8 | Oldest stored byte |
| rx_level | output | 5 | Number of stored bytes |
| data_ready | output | 1 | Queue holds data |
| overrun | output | 1 | A byte was dropped on a full queue |
| parity_err | output | 1 | Merged parity error |
| framing_err | output | 1 | Merged framing error |
| break_det | output | 1 | Merged break indication |
| err_summary | output | 1 | Any error recorded since the last status read |
| line_event | output | 1 | Line-status event |
| data_event | output | 1 | Fill reached the trigger level |
| timeout_event | output | 1 | Character timeout |

## Verification
A corrupt pointer or count shows up at the first pop after it: `rd_data` then differs from the scoreboard's oldest byte, and `rx_level` departs from the model size at once. A wrong flag merge shows as an error bit one cycle early or late around the pop that moves the faulty byte to the head. A wrong timer shows as a `timeout_event` one cycle away from the exact 4 × `char_clks` edge. The bench probes that edge on both sides.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned TMO_CHARS = 4;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_flags_t;

  typedef struct packed {
    rx_flags_t         flags;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  // fill level at which the data event fires
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // idle cycles before a character timeout
  function automatic int unsigned tmo_cycles(input int unsigned cpc);
    return cpc * TMO_CHARS;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  rx_entry_t       wr_entry,
  input  logic            rd_req,
  input  logic            clear,
  output rx_entry_t       head,
  output logic [CW-1:0]   count,
  output logic            rd_take,
  output logic            ovf_drop,
  output logic            head_load,
  output rx_flags_t       head_flags
);
  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_next;
  logic [CW-1:0] cnt_q;
  logic          full, empty, wr_take;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign rd_next = ptr_inc(rd_ptr);
  assign rd_take = rd_req && !empty && !clear;
  assign wr_take = wr_req && !clear && (!full || rd_take);
  assign ovf_drop = wr_req && !clear && full && !rd_take;

  // decide which byte becomes the head and whether its flags are merged
  always_comb begin
    head_load  = 1'b0;
    head_flags = '0;
    if (rd_take && cnt_q > CW'(1)) begin
      head_load  = 1'b1;
      head_flags = mem[rd_next].flags;
    end else if (wr_take && (empty || (rd_take && cnt_q == CW'(1)))) begin
      head_load  = 1'b1;
      head_flags = wr_entry.flags;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_take) wr_ptr <= ptr_inc(wr_ptr);
      if (rd_take) rd_ptr <= rd_next;
      case ({wr_take, rd_take})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ovf_drop,
  input  logic      head_load,
  input  rx_flags_t head_flags,
  input  logic      lsr_read,
  output logic      overrun,
  output logic      parity_err,
  output logic      framing_err,
  output logic      break_det,
  output logic      err_summary
);
  logic set_ovr, set_par, set_frm, set_brk, set_any;

  assign set_ovr = ovf_drop;
  assign set_par = head_load && head_flags.par;
  assign set_frm = head_load && head_flags.frm;
  assign set_brk = head_load && head_flags.brk;
  assign set_any = set_ovr || set_par || set_frm || set_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun     <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      break_det   <= 1'b0;
      err_summary <= 1'b0;
    end else begin
      overrun     <= (overrun     && !lsr_read) || set_ovr;
      parity_err  <= (parity_err  && !lsr_read) || set_par;
      framing_err <= (framing_err && !lsr_read) || set_frm;
      break_det   <= (break_det   && !lsr_read) || set_brk;
      err_summary <= (err_summary && !lsr_read) || set_any;
    end
  end
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
  import rxq_pkg::*;
#(
  parameter int unsigned CCW = 12,
  parameter int unsigned CW  = 5,
  localparam int unsigned TW = CCW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_req,
  input  logic           rd_take,
  input  logic           clear,
  input  logic [CW-1:0]  count,
  input  logic [CCW-1:0] char_clks,
  output logic           tmo_restart,
  output logic           timeout
);
  logic [TW-1:0] cnt_q, limit;
  logic          run_q, stop;

  assign limit       = TW'(tmo_cycles(32'(char_clks)));
  assign stop        = clear || (rd_take && count == CW'(1) && !wr_req);
  assign tmo_restart = !clear && (wr_req || (rd_take && count > CW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (stop) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (tmo_restart) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q && cnt_q < limit) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  assign timeout = run_q && (cnt_q >= limit);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CCW   = 12,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_par,
  input  logic              push_frm,
  input  logic              push_brk,
  input  logic              pop,
  input  logic [1:0]        trig_sel,
  input  logic              fifo_clear,
  input  logic              lsr_read,
  input  logic [CCW-1:0]    char_clks,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     rx_level,
  output logic              data_ready,
  output logic              overrun,
  output logic              parity_err,
  output logic              framing_err,
  output logic              break_det,
  output logic              err_summary,
  output logic              line_event,
  output logic              data_event,
  output logic              timeout_event
);
  rx_entry_t wr_entry, head;
  rx_flags_t head_flags;
  logic      rd_take, ovf_drop, head_load, tmo_restart;

  assign wr_entry = '{flags: '{brk: push_brk, frm: push_frm, par: push_par},
                      data: push_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (push_valid),
    .wr_entry   (wr_entry),
    .rd_req     (pop),
    .clear      (fifo_clear),
    .head       (head),
    .count      (rx_level),
    .rd_take    (rd_take),
    .ovf_drop   (ovf_drop),
    .head_load  (head_load),
    .head_flags (head_flags)
  );

  rxq_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovf_drop    (ovf_drop),
    .head_load   (head_load),
    .head_flags  (head_flags),
    .lsr_read    (lsr_read),
    .overrun     (overrun),
    .parity_err  (parity_err),
    .framing_err (framing_err),
    .break_det   (break_det),
    .err_summary (err_summary)
  );

  rxq_timer #(.CCW(CCW), .CW(CW)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (push_valid),
    .rd_take     (rd_take),
    .clear       (fifo_clear),
    .count       (rx_level),
    .char_clks   (char_clks),
    .tmo_restart (tmo_restart),
    .timeout     (timeout_event)
  );

  assign rd_data    = head.data;
  assign data_ready = (rx_level != '0);
  assign data_event = 32'(rx_level) >= trig_level(trig_sel);
  assign line_event = overrun || parity_err || framing_err || break_det;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CCW   = 12,
  parameter int unsigned CW    = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           push_valid,
  input logic           pop,
  input logic           fifo_clear,
  input logic           lsr_read,
  input logic [CCW-1:0] char_clks,
  input logic [CW-1:0]  rx_level,
  input logic           ovf_drop,
  input logic           head_load,
  input logic           overrun,
  input logic           parity_err,
  input logic           framing_err,
  input logic           break_det,
  input logic           err_summary,
  input logic           data_event,
  input logic           timeout_event,
  input logic           tmo_restart
);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_level) <= DEPTH);

  p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_clear |=> (rx_level == $past(rx_level) ||
                     rx_level == $past(rx_level) + CW'(1) ||
                     rx_level == $past(rx_level) - CW'(1)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_drop |=> (overrun && err_summary && 32'(rx_level) == DEPTH));

  p_status_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_read && !ovf_drop && !head_load) |=>
      !(overrun || parity_err || framing_err || break_det || err_summary));

  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_restart && char_clks != '0) |=> !timeout_event);

  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> (rx_level == '0 && !data_event && !timeout_event));

  p_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && rx_level == '0 && !push_valid && !fifo_clear) |=> rx_level == '0);
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH), .CCW(CCW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .push_valid    (push_valid),
  .pop           (pop),
  .fifo_clear    (fifo_clear),
  .lsr_read      (lsr_read),
  .char_clks     (char_clks),
  .rx_level      (rx_level),
  .ovf_drop      (ovf_drop),
  .head_load     (head_load),
  .overrun       (overrun),
  .parity_err    (parity_err),
  .framing_err   (framing_err),
  .break_det     (break_det),
  .err_summary   (err_summary),
  .data_event    (data_event),
  .timeout_event (timeout_event),
  .tmo_restart   (tmo_restart)
);

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 0, push_par = 0, push_frm = 0, push_brk = 0;
  logic [7:0] push_data = '0;
  logic       pop = 0, fifo_clear = 0, lsr_read = 0;
  logic [1:0] trig_sel = '0;
  logic [11:0] char_clks = 12'd3;
  logic [7:0] rd_data;
  logic [4:0] rx_level;
  logic data_ready, overrun, parity_err, framing_err, break_det;
  logic err_summary, line_event, data_event, timeout_event;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_queue uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_par(push_par), .push_frm(push_frm), .push_brk(push_brk), .pop(pop),
    .trig_sel(trig_sel), .fifo_clear(fifo_clear), .lsr_read(lsr_read),
    .char_clks(char_clks), .rd_data(rd_data), .rx_level(rx_level),
    .data_ready(data_ready), .overrun(overrun), .parity_err(parity_err),
    .framing_err(framing_err), .break_det(break_det), .err_summary(err_summary),
    .line_event(line_event), .data_event(data_event), .timeout_event(timeout_event)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // driver: offers one byte and records it in the scoreboard if it fits
  task automatic push_byte(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk);
    push_valid = 1; push_data = d; push_par = p; push_frm = f; push_brk = b;
    if (exp_q.size() < DEPTH) exp_q.push_back(d);
    @(negedge clk);
    push_valid = 0; push_par = 0; push_frm = 0; push_brk = 0;
  endtask

  // monitor: compares the head against the scoreboard, then reads it out
  task automatic pop_byte();
    @(negedge clk);
    if (exp_q.size() > 0) chk("R1 head byte", int'(rd_data), int'(exp_q.pop_front()));
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic read_lsr();
    @(negedge clk);
    lsr_read = 1;
    @(negedge clk);
    lsr_read = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(2);
    rst_n = 1;
    idle(1);
    chk("R2 reset level", int'(rx_level), 0);
    chk("R2 reset ready", int'(data_ready), 0);
    chk("R12 reset line event", int'(line_event), 0);
    chk("R8 reset timeout", int'(timeout_event), 0);

    // basic ordering and triggers
    trig_sel = 2'd1;
    push_byte(8'hA1, 0, 0, 0);
    chk("R7 below trigger 4", int'(data_event), 0);
    trig_sel = 2'd0;
    @(negedge clk);
    chk("R7 trigger 1", int'(data_event), 1);
    trig_sel = 2'd1;
    push_byte(8'hB2, 0, 0, 0);
    push_byte(8'hC3, 0, 0, 0);
    chk("R2 level 3", int'(rx_level), 3);
    chk("R2 ready", int'(data_ready), 1);
    chk("R7 level 3 under 4", int'(data_event), 0);
    push_byte(8'hD4, 0, 0, 0);
    chk("R7 level 4 at 4", int'(data_event), 1);
    for (int i = 0; i < 4; i++) pop_byte();
    chk("R2 drained ready", int'(data_ready), 0);

    // per-byte flag merging
    push_byte(8'h11, 1, 0, 0);
    chk("R4 parity merged", int'(parity_err), 1);
    chk("R4 summary", int'(err_summary), 1);
    chk("R12 line event", int'(line_event), 1);
    push_byte(8'h22, 0, 1, 0);
    chk("R5 framing held back", int'(framing_err), 0);
    read_lsr();
    chk("R6 parity cleared", int'(parity_err), 0);
    chk("R6 summary cleared", int'(err_summary), 0);
    pop_byte();
    chk("R5 framing at head", int'(framing_err), 1);
    chk("R5 ready kept", int'(data_ready), 1);
    read_lsr();
    pop_byte();
    chk("R6 framing cleared", int'(framing_err), 0);
    chk("R2 empty after pop", int'(data_ready), 0);

    // overrun on a full queue
    trig_sel = 2'd3;
    for (int i = 0; i < 13; i++) push_byte(8'(8'h40 + i), 0, 0, 0);
    chk("R7 level 13 under 14", int'(data_event), 0);
    push_byte(8'h4D, 0, 0, 0);
    chk("R7 level 14", int'(data_event), 1);
    push_byte(8'h4E, 0, 0, 0);
    push_byte(8'h4F, 0, 0, 0);
    chk("R3 no overrun when just full", int'(overrun), 0);
    push_byte(8'hEE, 0, 0, 1);
    chk("R3 overrun set", int'(overrun), 1);
    chk("R3 summary set", int'(err_summary), 1);
    chk("R3 level held", int'(rx_level), DEPTH);
    chk("R3 dropped break flag", int'(break_det), 0);
    for (int i = 0; i < DEPTH; i++) pop_byte();
    chk("R3 drained", int'(rx_level), 0);
    read_lsr();
    chk("R6 overrun cleared", int'(overrun), 0);

    // pop on empty
    pop_byte();
    chk("R11 level stays", int'(rx_level), 0);
    chk("R11 no status", int'(line_event), 0);

    // timeout: 4 * 3 = 12 cycles after the restart edge
    push_byte(8'h55, 0, 0, 0);
    idle(11);
    chk("R8 one cycle early", int'(timeout_event), 0);
    idle(1);
    chk("R8 timeout on time", int'(timeout_event), 1);
    idle(3);
    chk("R8 timeout held", int'(timeout_event), 1);
    pop_byte();
    idle(20);
    chk("R9 stopped when empty", int'(timeout_event), 0);

    push_byte(8'h66, 0, 0, 0);
    push_byte(8'h77, 0, 0, 0);
    idle(8);
    pop_byte();
    idle(11);
    chk("R8 restart by pop early", int'(timeout_event), 0);
    idle(1);
    chk("R8 restart by pop on time", int'(timeout_event), 1);

    // clear keeps error bits
    push_byte(8'h88, 1, 0, 0);
    chk("R10 pre parity", int'(parity_err), 0);
    idle(12);
    @(negedge clk);
    fifo_clear = 1;
    @(negedge clk);
    fifo_clear = 0;
    exp_q.delete();
    chk("R10 level zero", int'(rx_level), 0);
    chk("R10 ready low", int'(data_ready), 0);
    chk("R10 timeout low", int'(timeout_event), 0);
    chk("R10 data event low", int'(data_event), 0);
    push_byte(8'h99, 1, 0, 0);
    chk("R4 parity after clear", int'(parity_err), 1);
    @(negedge clk);
    fifo_clear = 1;
    @(negedge clk);
    fifo_clear = 0;
    exp_q.delete();
    chk("R10 error bits kept", int'(parity_err), 1);

    finish_run();
  end
endmodule